// File: doc/BRIEF.md
# FIFO-to-Channel List Sequencer

This block decides, once per frame, which FIFO serves which time-slot channel and in what order. A host programs a chained list of up to 64 entries through a small write-only register port. Each entry holds a link naming the FIFO that owns the following entry, a channel number and an 8-bit configuration word. The configuration word covers framing mode, byte handling and interrupt masking, and the block passes it through without decoding it. A separate start register names the FIFO that owns entry 0.

When a frame-sync pulse arrives in list mode, the block walks the list from entry 0 and emits one tuple per clock: entry index, FIFO number, direction, channel and configuration. The walk ends after the entry whose link carries the end mark, or after the last array entry. Because a FIFO may be named in several links, one FIFO can serve several channels in a single frame. The downstream data path consumes the tuples. The FIFO storage and the serial framing are not part of this block.

Top module: `fifo_chan_seq`

## Requirements
- R1: After reset, `tup_valid` is low, `fifo_sel` is 0, the start register is invalid and every link carries the end mark. A frame sync on an unprogrammed list therefore produces no tuple.
- R2: A write to address 0 sets the list index while `list_mode` is high. While `list_mode` is low it sets `fifo_sel` to `host_wdata[5:0]` ({direction bit 5, FIFO bits 4:0}). `fifo_sel` never changes while `list_mode` is high.
- R3: Address 1 writes the start register and address 2 writes the link of the indexed entry. Both use the layout bit 7 valid, bit 5 direction, bits 4:0 FIFO number; an entry whose valid bit is clear is the end mark. Address 3 writes the channel (`host_wdata[4:0]`) of the indexed entry and address 4 writes its configuration byte.
- R4: A frame sync sampled high at a clock edge starts a walk. The tuple for entry 0 appears after the following edge, and each later tuple follows one cycle after the one before it, with `tup_idx` going up by one.
- R5: The tuple for entry 0 carries the start register's FIFO and direction. The tuple for entry i>0 carries the link stored in entry i-1. The channel and configuration always come from entry i itself.
- R6: The same FIFO may appear in several tuples of one walk.
- R7: An entry whose link carries the end mark is still emitted, and no tuple follows it. If the start register is invalid, the walk emits nothing.
- R8: When no end mark appears, the walk stops after entry 63.
- R9: A frame sync during a walk drives `tup_valid` low at that edge, and the walk then restarts from entry 0.
- R10: While `list_mode` is low, frame sync is ignored, and a walk in progress emits nothing from the next edge onward.
- R11: A host write to the entry being fetched at the same edge leaves the tuple emitted at that edge with the old contents. Later fetches of that entry return the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_mode | input | 1 | Selects list operation and the meaning of address 0 |
| frame_sync | input | 1 | Frame strobe that starts or restarts a walk |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 8 | Host write data |
| fifo_sel | output | 6 | Plain FIFO-select register {direction, FIFO} |
| tup_valid | output | 1 | Tuple strobe |
| tup_idx | output | 6 | List entry of the tuple |
| tup_fifo | output | 5 | FIFO number of the tuple |
| tup_dir | output | 1 | FIFO direction of the tuple |
| tup_chan | output | 5 | Channel of the tuple |
| tup_cfg | output | 8 | Configuration word of the tuple |

## Verification
Two pairs of functions can land on the same edge. In the first, a host write and the walk's fetch hit the same entry. The bench points the index at entry 5 and raises the channel write so that it lands on the edge that fetches entry 5. It then expects the old channel in that tuple and the new channel in the next walk. In the second, a frame sync meets an ongoing emission. The bench pulses sync after ten tuples and expects a single idle cycle followed by entry 0, with the rest of the list compared against a model walked from the bench's own copy of the list.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [2:0] {
    RA_SELECT = 3'd0,
    RA_FIRST  = 3'd1,
    RA_NEXT   = 3'd2,
    RA_CHAN   = 3'd3,
    RA_CFG    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/fcs_host_regs.sv
module fcs_host_regs
  import fcs_pkg::*;
#(
  parameter int DW     = 8,
  parameter int FIFO_W = 5,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              list_mode,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [IDX_W-1:0]  idx,
  output logic [FIFO_W:0]   fifo_sel,
  output logic              first_v,
  output logic [FIFO_W:0]   first_fifo,
  output logic              wr_next,
  output logic              wr_chan,
  output logic              wr_cfg
);
  localparam int VBIT = DW - 1;

  reg_addr_e ra;

  always_comb begin
    ra      = reg_addr_e'(host_addr);
    wr_next = host_we && (ra == RA_NEXT);
    wr_chan = host_we && (ra == RA_CHAN);
    wr_cfg  = host_we && (ra == RA_CFG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      fifo_sel   <= '0;
      first_v    <= 1'b0;
      first_fifo <= '0;
    end else if (host_we) begin
      case (ra)
        RA_SELECT: begin
          if (list_mode) idx      <= host_wdata[IDX_W-1:0];
          else           fifo_sel <= host_wdata[FIFO_W:0];
        end
        RA_FIRST: begin
          first_v    <= host_wdata[VBIT];
          first_fifo <= host_wdata[FIFO_W:0];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fcs_list_store.sv
module fcs_list_store #(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  parameter int FIFO_W = 5,
  parameter int CH_W   = 5,
  parameter int CFG_W  = 8,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              wr_next,
  input  logic              wr_chan,
  input  logic              wr_cfg,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_nvalid,
  output logic [FIFO_W:0]   rd_nfifo,
  output logic [CH_W-1:0]   rd_chan,
  output logic [CFG_W-1:0]  rd_cfg
);
  logic [FIFO_W:0]  next_mem [DEPTH];
  logic [CH_W-1:0]  chan_mem [DEPTH];
  logic [CFG_W-1:0] cfg_mem  [DEPTH];
  logic [DEPTH-1:0] nvalid_q;

  // RAM-style arrays: write port from host, registered read-first port for the walk.
  always_ff @(posedge clk) begin
    if (wr_next) next_mem[wr_idx] <= wr_data[FIFO_W:0];
    if (wr_chan) chan_mem[wr_idx] <= wr_data[CH_W-1:0];
    if (wr_cfg)  cfg_mem[wr_idx]  <= wr_data[CFG_W-1:0];
    if (rd_en) begin
      rd_nfifo <= next_mem[rd_idx];
      rd_chan  <= chan_mem[rd_idx];
      rd_cfg   <= cfg_mem[rd_idx];
    end
  end

  // Link valid bits live in flops so reset can mark every entry as end of list.
  always_ff @(posedge clk) begin
    if (rst)          nvalid_q         <= '0;
    else if (wr_next) nvalid_q[wr_idx] <= wr_data[DW-1];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_nvalid <= 1'b0;
    else if (rd_en) rd_nvalid <= nvalid_q[rd_idx];
  end
endmodule

// File: rtl/fcs_walk_ctrl.sv
module fcs_walk_ctrl #(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  parameter int FIFO_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              list_mode,
  input  logic              frame_sync,
  input  logic              first_v,
  input  logic [FIFO_W:0]   first_fifo,
  input  logic              rd_nvalid,
  input  logic [FIFO_W:0]   rd_nfifo,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              tup_valid,
  output logic [IDX_W-1:0]  tup_idx,
  output logic [FIFO_W:0]   tup_fifo
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic             active;
  logic             first_step;
  logic [IDX_W-1:0] ptr;
  logic             owner_v;
  logic [FIFO_W:0]  owner;
  logic             emit;

  always_comb begin
    owner_v = first_step ? first_v    : rd_nvalid;
    owner   = first_step ? first_fifo : rd_nfifo;
    emit    = active && owner_v && list_mode && !frame_sync;
    rd_en   = emit;
    rd_idx  = ptr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active     <= 1'b0;
      first_step <= 1'b0;
      ptr        <= '0;
      tup_valid  <= 1'b0;
      tup_idx    <= '0;
      tup_fifo   <= '0;
    end else begin
      tup_valid <= emit;
      if (emit) begin
        tup_idx    <= ptr;
        tup_fifo   <= owner;
        ptr        <= ptr + 1'b1;
        first_step <= 1'b0;
        active     <= (ptr != LAST);
      end
      if (!list_mode) begin
        active <= 1'b0;
      end else if (frame_sync) begin
        active     <= 1'b1;
        first_step <= 1'b1;
        ptr        <= '0;
      end else if (active && !owner_v) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fifo_chan_seq.sv
module fifo_chan_seq #(
  parameter int DEPTH  = 64,
  parameter int FIFO_W = 5,
  parameter int CH_W   = 5,
  parameter int CFG_W  = 8,
  parameter int DW     = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              list_mode,
  input  logic              frame_sync,
  input  logic              host_we,
  input  logic [2:0]        host_addr,
  input  logic [DW-1:0]     host_wdata,
  output logic [FIFO_W:0]   fifo_sel,
  output logic              tup_valid,
  output logic [IDX_W-1:0]  tup_idx,
  output logic [FIFO_W-1:0] tup_fifo,
  output logic              tup_dir,
  output logic [CH_W-1:0]   tup_chan,
  output logic [CFG_W-1:0]  tup_cfg
);
  logic [IDX_W-1:0] idx;
  logic             first_v;
  logic [FIFO_W:0]  first_fifo;
  logic             wr_next, wr_chan, wr_cfg;
  logic             rd_en;
  logic [IDX_W-1:0] rd_idx;
  logic             rd_nvalid;
  logic [FIFO_W:0]  rd_nfifo;
  logic [FIFO_W:0]  tup_owner;

  fcs_host_regs #(.DW(DW), .FIFO_W(FIFO_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .list_mode(list_mode), .host_we(host_we),
    .host_addr(host_addr), .host_wdata(host_wdata), .idx(idx),
    .fifo_sel(fifo_sel), .first_v(first_v), .first_fifo(first_fifo),
    .wr_next(wr_next), .wr_chan(wr_chan), .wr_cfg(wr_cfg)
  );

  fcs_list_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .FIFO_W(FIFO_W),
                   .CH_W(CH_W), .CFG_W(CFG_W), .DW(DW)) u_store (
    .clk(clk), .rst(rst), .wr_idx(idx), .wr_data(host_wdata),
    .wr_next(wr_next), .wr_chan(wr_chan), .wr_cfg(wr_cfg),
    .rd_en(rd_en), .rd_idx(rd_idx), .rd_nvalid(rd_nvalid),
    .rd_nfifo(rd_nfifo), .rd_chan(tup_chan), .rd_cfg(tup_cfg)
  );

  fcs_walk_ctrl #(.DEPTH(DEPTH), .IDX_W(IDX_W), .FIFO_W(FIFO_W)) u_walk (
    .clk(clk), .rst(rst), .list_mode(list_mode), .frame_sync(frame_sync),
    .first_v(first_v), .first_fifo(first_fifo), .rd_nvalid(rd_nvalid),
    .rd_nfifo(rd_nfifo), .rd_en(rd_en), .rd_idx(rd_idx),
    .tup_valid(tup_valid), .tup_idx(tup_idx), .tup_fifo(tup_owner)
  );

  assign tup_fifo = tup_owner[FIFO_W-1:0];
  assign tup_dir  = tup_owner[FIFO_W];
endmodule

// File: rtl/fcs_seq_chk.sv
module fcs_seq_chk #(
  parameter int DEPTH  = 64,
  parameter int IDX_W  = 6,
  parameter int FIFO_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             list_mode,
  input logic             frame_sync,
  input logic             tup_valid,
  input logic [IDX_W-1:0] tup_idx,
  input logic [FIFO_W:0]  fifo_sel
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !tup_valid);

  assert_sel_hold_R2: assert property (@(posedge clk) disable iff (rst)
    list_mode |=> $stable(fifo_sel));

  assert_start_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (tup_valid && !$past(tup_valid)) |-> (tup_idx == '0));

  assert_one_step_R4: assert property (@(posedge clk) disable iff (rst)
    (tup_valid && $past(tup_valid)) |-> (tup_idx == $past(tup_idx) + 1'b1));

  assert_bound_R8: assert property (@(posedge clk) disable iff (rst)
    (tup_valid && tup_idx == LAST) |=> !tup_valid);

  assert_sync_gap_R9: assert property (@(posedge clk) disable iff (rst)
    frame_sync |=> !tup_valid);

  assert_mode_gate_R10: assert property (@(posedge clk) disable iff (rst)
    !list_mode |=> !tup_valid);
endmodule

bind fifo_chan_seq fcs_seq_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W), .FIFO_W(FIFO_W)) u_chk (
  .clk(clk), .rst(rst), .list_mode(list_mode), .frame_sync(frame_sync),
  .tup_valid(tup_valid), .tup_idx(tup_idx), .fifo_sel(fifo_sel)
);

// File: tb/fifo_chan_seq_tb.sv
module fifo_chan_seq_tb;
  localparam int CLK_P = 10;
  localparam int DEPTH = 64;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       list_mode = 1'b0;
  logic       frame_sync = 1'b0;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [5:0] fifo_sel;
  logic       tup_valid;
  logic [5:0] tup_idx;
  logic [4:0] tup_fifo;
  logic       tup_dir;
  logic [4:0] tup_chan;
  logic [7:0] tup_cfg;

  fifo_chan_seq u_dut (
    .clk(clk), .rst(rst), .list_mode(list_mode), .frame_sync(frame_sync),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .fifo_sel(fifo_sel), .tup_valid(tup_valid), .tup_idx(tup_idx),
    .tup_fifo(tup_fifo), .tup_dir(tup_dir), .tup_chan(tup_chan), .tup_cfg(tup_cfg)
  );

  initial forever #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench copy of the programmed list
  logic [7:0] m_next [DEPTH];
  logic [7:0] m_chan [DEPTH];
  logic [7:0] m_cfg  [DEPTH];
  logic [7:0] m_first;
  logic [5:0] m_idx;
  logic [5:0] m_sel;
  int exp_t [DEPTH];
  int exp_n;
  int got_t [DEPTH+2];
  int got_n;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int pk(int idx, int fifo, int dir, int ch, int cfg);
    return (idx << 19) | (fifo << 14) | (dir << 13) | (ch << 8) | cfg;
  endfunction

  function automatic int cur_tuple();
    return pk(int'(tup_idx), int'(tup_fifo), int'(tup_dir), int'(tup_chan), int'(tup_cfg));
  endfunction

  task automatic compute_exp();
    logic [7:0] own;
    own = m_first;
    exp_n = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!own[7]) break;
      exp_t[exp_n] = pk(i, int'(own[4:0]), int'(own[5]), int'(m_chan[i][4:0]), int'(m_cfg[i]));
      exp_n++;
      own = m_next[i];
    end
  endtask

  task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
    case (a)
      3'd0: if (list_mode) m_idx = d[5:0]; else m_sel = d[5:0];
      3'd1: m_first = d;
      3'd2: m_next[m_idx] = d;
      3'd3: m_chan[m_idx] = d;
      3'd4: m_cfg[m_idx] = d;
      default: ;
    endcase
  endtask

  task automatic prog_entry(input int i, input logic [7:0] nx, input logic [7:0] ch,
                            input logic [7:0] cf);
    host_wr(3'd0, 8'(i));
    host_wr(3'd2, nx);
    host_wr(3'd3, ch);
    host_wr(3'd4, cf);
  endtask

  task automatic sync_pulse();
    @(negedge clk); frame_sync = 1'b1;
    @(negedge clk); frame_sync = 1'b0;
  endtask

  task automatic collect();
    for (int k = 0; k < DEPTH + 2; k++) begin
      @(negedge clk);
      if (!tup_valid) break;
      got_t[got_n] = cur_tuple();
      got_n++;
    end
  endtask

  task automatic compare(input string req);
    chk(got_n == exp_n, {req, " tuple count"}, got_n, exp_n);
    for (int k = 0; k < got_n && k < exp_n; k++)
      chk(got_t[k] == exp_t[k], {req, " tuple contents"}, got_t[k], exp_t[k]);
  endtask

  task automatic walk_check(input string req);
    compute_exp();
    got_n = 0;
    sync_pulse();
    collect();
    compare(req);
  endtask

  task automatic t_reset();
    chk(tup_valid == 1'b0, "R1 valid after reset", int'(tup_valid), 0);
    chk(fifo_sel == 6'd0, "R1 fifo_sel after reset", int'(fifo_sel), 0);
    list_mode = 1'b1;
    walk_check("R1 unprogrammed walk");
    chk(got_n == 0, "R1 nothing emitted", got_n, 0);
  endtask

  task automatic t_regmap();
    list_mode = 1'b0;
    host_wr(3'd0, 8'h2B);
    chk(fifo_sel == m_sel, "R2 select written outside list mode", int'(fifo_sel), int'(m_sel));
    list_mode = 1'b1;
    host_wr(3'd0, 8'h03);
    chk(fifo_sel == 6'h2B, "R2 select kept in list mode", int'(fifo_sel), 'h2B);
  endtask

  task automatic t_recur();
    int n3;
    host_wr(3'd1, 8'hA3);
    prog_entry(0, 8'h87, 8'd4,  8'h11);
    prog_entry(1, 8'hA3, 8'd9,  8'h22);
    prog_entry(2, 8'h83, 8'd17, 8'h33);
    prog_entry(3, 8'h1F, 8'd30, 8'hC4);
    walk_check("R5 owner chaining");
    chk(got_n == 4, "R7 stop after end-marked entry", got_n, 4);
    n3 = 0;
    for (int k = 0; k < got_n; k++) if (((got_t[k] >> 14) & 31) == 3) n3++;
    chk(n3 == 3, "R6 FIFO 3 recurs", n3, 3);
    chk(got_t[3] == pk(3, 3, 0, 30, 'hC4), "R3 entry fields", got_t[3], pk(3, 3, 0, 30, 'hC4));
  endtask

  task automatic t_first_invalid();
    host_wr(3'd1, 8'h23);
    walk_check("R7 invalid start");
    chk(got_n == 0, "R7 invalid start emits nothing", got_n, 0);
    host_wr(3'd1, 8'hA3);
  endtask

  task automatic t_full();
    for (int i = 0; i < DEPTH; i++)
      prog_entry(i, 8'h80 | (i[0] ? 8'h20 : 8'h00) | 8'((i * 5) % 32),
                 8'((i * 7) % 32), 8'((i * 3 + 1) % 256));
    walk_check("R4 R8 full list");
    chk(got_n == DEPTH, "R8 stops after last entry", got_n, DEPTH);
  endtask

  task automatic t_restart();
    compute_exp();
    got_n = 0;
    sync_pulse();
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk(tup_valid && cur_tuple() == exp_t[k], "R9 before restart", cur_tuple(), exp_t[k]);
    end
    frame_sync = 1'b1;
    @(negedge clk);
    frame_sync = 1'b0;
    chk(tup_valid == 1'b0, "R9 gap at restart edge", int'(tup_valid), 0);
    collect();
    compare("R9 restarted walk");
  endtask

  task automatic t_write_during();
    host_wr(3'd0, 8'd5);
    compute_exp();
    got_n = 0;
    sync_pulse();
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      got_t[got_n] = cur_tuple();
      got_n++;
    end
    host_we = 1'b1; host_addr = 3'd3; host_wdata = 8'h15;
    @(negedge clk);
    host_we = 1'b0;
    if (tup_valid) begin
      got_t[got_n] = cur_tuple();
      got_n++;
    end
    collect();
    compare("R11 old contents during write");
    m_chan[5] = 8'h15;
    walk_check("R11 new contents next walk");
  endtask

  task automatic t_mode_abort();
    int seen;
    compute_exp();
    sync_pulse();
    for (int k = 0; k < 5; k++) @(negedge clk);
    list_mode = 1'b0;
    @(negedge clk);
    chk(tup_valid == 1'b0, "R10 walk stops when mode drops", int'(tup_valid), 0);
    seen = 0;
    sync_pulse();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (tup_valid) seen++;
    end
    chk(seen == 0, "R10 sync ignored outside list mode", seen, 0);
    list_mode = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_next[i] = 8'h1F; m_chan[i] = '0; m_cfg[i] = '0;
    end
    m_first = '0; m_idx = '0; m_sel = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regmap();
    t_recur();
    t_first_invalid();
    t_full();
    t_restart();
    t_write_during();
    t_mode_abort();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule